// File: doc/BRIEF.md
# Cache Maintenance Operation Decoder

This block sits behind the system-control register port of a processor core and turns each access to the cache-maintenance register into a single registered outcome. An access is described by the selector pair (CRm, Opcode_2), a direction flag, the 32-bit data word and the current privilege level. One cycle after the access, exactly one of three things happens. It may raise a one-hot operation strobe, set the no-operation flag, or pulse an undefined-instruction exception.

When an operation is accepted, the block also formats its operand from the data word. Set/way operations get a way number and a set index whose width follows the configured L1 cache size. Line-address operations get the line address with the offset bits removed. Should-be-zero bits are masked out and are never trapped. The cache walk, barrier sequencing and the wait for an interrupt are done by other logic that consumes the strobes.

Top module: `cmo_decoder`

## Requirements
- R1: While reset is held and in the cycle after it is released, all strobes, `nop_o`, `undef_o` and all operand outputs are zero.
- R2: Any read request raises `undef_o` one cycle later, whatever the selector pair and the privilege level.
- R3: A write whose (CRm, Opcode_2) pair is not in the R6 table and not in the R4 list raises `undef_o` one cycle later.
- R4: A privileged write with one of the pairs (0,4), (1,6), (5,6) or (5,7) sets `nop_o` one cycle later and raises no strobe.
- R5: Only three pairs are accepted in user mode (`priv_i`=0): (5,4), (10,4) and (10,5). Every other pair in R4 or R6 raises `undef_o` in user mode.
- R6: An accepted write raises `op_strobe_o[k]` one cycle later. The mapping from (CRm,Op2) to k is: (5,0)->0, (1,0)->1, (5,1)->2, (5,4)->3, (6,1)->4, (6,2)->5, (10,1)->6, (10,2)->7, (10,4)->8, (10,5)->9, (11,1)->10, (14,1)->11, (14,2)->12. Set/way operations are k = 5, 7 and 12. Line-address operations are k = 2, 4, 6, 10 and 11.
- R7: Every valid request gives exactly one of {a strobe bit, `nop_o`, `undef_o`} for exactly one cycle. A cycle with no request gives none of them.
- R8: For set/way operations, `way_o` is data bits [31:30]. `set_o` holds data bits [5+W-1:5] in its low W bits, with W = 5 + `cache_size_i` (codes 0..4 for 4KB..64KB), and zeros above them. Set bits 29 down to 5+W, and bits [4:0], do not affect any output.
- R9: Size codes 5, 6 and 7 give the same set width as code 0 (W = 5).
- R10: For line-address operations, `line_addr_o` is data bits [31:5], and bits [4:0] do not affect it.
- R11: Any operand output that does not belong to the accepted operation's format is zero. All operand outputs are zero when `nop_o` or `undef_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Access request this cycle |
| req_read_i | input | 1 | 1 = read access, 0 = write |
| req_crm_i | input | 4 | CRm selector |
| req_op2_i | input | 3 | Opcode_2 selector |
| req_wdata_i | input | 32 | Write data / operand word |
| priv_i | input | 1 | 1 = privileged mode, 0 = user mode |
| cache_size_i | input | 3 | L1 size code: 0=4KB .. 4=64KB, others as 4KB |
| op_strobe_o | output | 13 | One-hot operation strobe (index per R6) |
| nop_o | output | 1 | Accepted no-operation access |
| undef_o | output | 1 | Undefined-instruction exception pulse |
| way_o | output | 2 | Way number for set/way operations |
| set_o | output | 9 | Set index, masked to the configured width |
| line_addr_o | output | 27 | Line address for address-format operations |

## Verification
The bench builds the block with its default parameters. These are a 32-bit word, a 2-bit way, a 5-bit line offset and five cache sizes, so set widths from 5 to 9 bits can all be reached. Random data words keep setting the should-be-zero bits, both above the set field and in the line offset, which exercises the masking at every size code. The out-of-range codes 5 to 7 are also drawn on purpose. The selector pairs come half from the supported list and half from the full 128-pair space, in both privilege levels, so trapped, silent and user-permitted accesses all occur many times.

// File: rtl/cmo_pkg.sv
// Package: shared types and the fixed encoding table of the cache
// maintenance register decoder.
// Assumes: selector fields are CRm (4 bits) and Opcode_2 (3 bits).
package cmo_pkg;

    localparam int CRM_W   = 4;
    localparam int OP2_W   = 3;
    localparam int NUM_OPS = 13;

    // Operation index; the value is the strobe bit position.
    typedef enum logic [3:0] {
        OP_IC_INV_ALL    = 4'd0,
        OP_IC_INV_ALL_IS = 4'd1,
        OP_IC_INV_LINE   = 4'd2,
        OP_ISYNC         = 4'd3,
        OP_DC_INV_LINE   = 4'd4,
        OP_DC_INV_SW     = 4'd5,
        OP_DC_CLN_LINE   = 4'd6,
        OP_DC_CLN_SW     = 4'd7,
        OP_DSYNC         = 4'd8,
        OP_DMEMB         = 4'd9,
        OP_DC_CLN_U_LINE = 4'd10,
        OP_DC_CI_LINE    = 4'd11,
        OP_DC_CI_SW      = 4'd12
    } op_e;

    // Operand format carried by an operation.
    typedef enum logic [1:0] {
        FMT_NONE   = 2'd0,
        FMT_SETWAY = 2'd1,
        FMT_ADDR   = 2'd2
    } fmt_e;

    // One row of the decode table.
    typedef struct packed {
        logic hit;      // pair is defined
        logic nop;      // accepted but performs nothing
        logic user_ok;  // allowed in user mode
        op_e  op;       // strobe index when not a nop
        fmt_e fmt;      // operand format
    } dec_t;

    // Strobe groupings used by checks.
    localparam logic [NUM_OPS-1:0] USER_MASK   = 13'b0_0011_0000_1000;
    localparam logic [NUM_OPS-1:0] SETWAY_MASK = 13'b1_0000_1010_0000;
    localparam logic [NUM_OPS-1:0] ADDR_MASK   = 13'b0_1100_0101_0100;

    // Build a table row.
    function automatic dec_t mk_row(logic nop, logic user_ok, op_e op, fmt_e fmt);
        dec_t r;
        r.hit     = 1'b1;
        r.nop     = nop;
        r.user_ok = user_ok;
        r.op      = op;
        r.fmt     = fmt;
        return r;
    endfunction

    // Decode table: sparse case list over {CRm, Opcode_2}.
    function automatic dec_t cmo_lookup(logic [CRM_W-1:0] crm, logic [OP2_W-1:0] op2);
        dec_t r;
        r = '0;
        case ({crm, op2})
            {4'd0,  3'd4}: r = mk_row(1'b1, 1'b0, OP_IC_INV_ALL,    FMT_NONE);
            {4'd1,  3'd0}: r = mk_row(1'b0, 1'b0, OP_IC_INV_ALL_IS, FMT_NONE);
            {4'd1,  3'd6}: r = mk_row(1'b1, 1'b0, OP_IC_INV_ALL,    FMT_NONE);
            {4'd5,  3'd0}: r = mk_row(1'b0, 1'b0, OP_IC_INV_ALL,    FMT_NONE);
            {4'd5,  3'd1}: r = mk_row(1'b0, 1'b0, OP_IC_INV_LINE,   FMT_ADDR);
            {4'd5,  3'd4}: r = mk_row(1'b0, 1'b1, OP_ISYNC,         FMT_NONE);
            {4'd5,  3'd6}: r = mk_row(1'b1, 1'b0, OP_IC_INV_ALL,    FMT_NONE);
            {4'd5,  3'd7}: r = mk_row(1'b1, 1'b0, OP_IC_INV_ALL,    FMT_NONE);
            {4'd6,  3'd1}: r = mk_row(1'b0, 1'b0, OP_DC_INV_LINE,   FMT_ADDR);
            {4'd6,  3'd2}: r = mk_row(1'b0, 1'b0, OP_DC_INV_SW,     FMT_SETWAY);
            {4'd10, 3'd1}: r = mk_row(1'b0, 1'b0, OP_DC_CLN_LINE,   FMT_ADDR);
            {4'd10, 3'd2}: r = mk_row(1'b0, 1'b0, OP_DC_CLN_SW,     FMT_SETWAY);
            {4'd10, 3'd4}: r = mk_row(1'b0, 1'b1, OP_DSYNC,         FMT_NONE);
            {4'd10, 3'd5}: r = mk_row(1'b0, 1'b1, OP_DMEMB,         FMT_NONE);
            {4'd11, 3'd1}: r = mk_row(1'b0, 1'b0, OP_DC_CLN_U_LINE, FMT_ADDR);
            {4'd14, 3'd1}: r = mk_row(1'b0, 1'b0, OP_DC_CI_LINE,    FMT_ADDR);
            {4'd14, 3'd2}: r = mk_row(1'b0, 1'b0, OP_DC_CI_SW,      FMT_SETWAY);
            default:       r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cmo_table_decode.sv
// Module: cmo_table_decode
// Looks up the selector pair, applies the direction and privilege rules
// and produces the unregistered outcome: one-hot strobe, nop or undef.
// Assumes: the caller qualifies all outputs with the request valid.
module cmo_table_decode
    import cmo_pkg::*;
(
    input  logic [CRM_W-1:0]   crm_i,
    input  logic [OP2_W-1:0]   op2_i,
    input  logic               read_i,
    input  logic               priv_i,
    output logic [NUM_OPS-1:0] strobe_o,
    output logic               nop_o,
    output logic               undef_o,
    output fmt_e               fmt_o
);

    dec_t entry;
    logic allowed;

    // Table lookup for the current selector pair.
    always_comb entry = cmo_lookup(crm_i, op2_i);

    // Access rule: defined pair, write only, privilege or user-permitted.
    always_comb allowed = entry.hit & ~read_i & (priv_i | entry.user_ok);

    // Outcome and format of the operand.
    always_comb begin
        undef_o = ~allowed;
        nop_o   = allowed & entry.nop;
        fmt_o   = (allowed && !entry.nop) ? entry.fmt : FMT_NONE;
    end

    // One strobe line per operation index.
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_strobe
        assign strobe_o[g] = allowed & ~entry.nop & (int'(entry.op) == g);
    end

endmodule

// File: rtl/cmo_operand_fmt.sv
// Module: cmo_operand_fmt
// Extracts way, set index and line address from the data word according
// to the operand format and the configured cache size.
// Assumes: size codes at or above NUM_SIZES select the smallest cache;
// should-be-zero bits are dropped, never reported.
module cmo_operand_fmt
    import cmo_pkg::*;
#(
    parameter  int DATA_W      = 32,
    parameter  int WAY_W       = 2,
    parameter  int LINE_LSB    = 5,
    parameter  int MIN_SET_W   = 5,
    parameter  int NUM_SIZES   = 5,
    parameter  int SIZE_CODE_W = 3,
    localparam int SET_W_MAX   = MIN_SET_W + NUM_SIZES - 1,
    localparam int ADDR_W      = DATA_W - LINE_LSB
) (
    input  logic [DATA_W-1:0]      wdata_i,
    input  logic [SIZE_CODE_W-1:0] size_i,
    input  fmt_e                   fmt_i,
    output logic [WAY_W-1:0]       way_o,
    output logic [SET_W_MAX-1:0]   set_o,
    output logic [ADDR_W-1:0]      addr_o
);

    int unsigned          set_bits;
    logic [SET_W_MAX-1:0] set_keep;
    logic [SET_W_MAX-1:0] raw_set;

    // Set width selected by the size code; out-of-range codes map to the smallest.
    always_comb begin
        if (int'(size_i) < NUM_SIZES)
            set_bits = unsigned'(MIN_SET_W + int'(size_i));
        else
            set_bits = unsigned'(MIN_SET_W);
    end

    // Per-bit keep mask for the set field.
    for (genvar b = 0; b < SET_W_MAX; b++) begin : g_set_mask
        assign set_keep[b] = (unsigned'(b) < set_bits);
    end

    // Widest possible set field taken straight from the word.
    always_comb raw_set = wdata_i[LINE_LSB +: SET_W_MAX];

    // Operand selection by format; unused fields stay zero.
    always_comb begin
        way_o  = '0;
        set_o  = '0;
        addr_o = '0;
        case (fmt_i)
            FMT_SETWAY: begin
                way_o = wdata_i[DATA_W-1 -: WAY_W];
                set_o = raw_set & set_keep;
            end
            FMT_ADDR: addr_o = wdata_i[DATA_W-1:LINE_LSB];
            default: ;
        endcase
    end

endmodule

// File: rtl/cmo_decoder.sv
// Module: cmo_decoder (top)
// Decodes accesses to the cache maintenance register into a registered
// one-cycle outcome (strobe, nop or undef) plus a formatted operand.
// Assumes: one request per cycle at most; synchronous active-low reset.
module cmo_decoder
    import cmo_pkg::*;
#(
    parameter  int DATA_W      = 32,
    parameter  int WAY_W       = 2,
    parameter  int LINE_LSB    = 5,
    parameter  int MIN_SET_W   = 5,
    parameter  int NUM_SIZES   = 5,
    parameter  int SIZE_CODE_W = 3,
    localparam int SET_W_MAX   = MIN_SET_W + NUM_SIZES - 1,
    localparam int ADDR_W      = DATA_W - LINE_LSB
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid_i,
    input  logic                   req_read_i,
    input  logic [CRM_W-1:0]       req_crm_i,
    input  logic [OP2_W-1:0]       req_op2_i,
    input  logic [DATA_W-1:0]      req_wdata_i,
    input  logic                   priv_i,
    input  logic [SIZE_CODE_W-1:0] cache_size_i,
    output logic [NUM_OPS-1:0]     op_strobe_o,
    output logic                   nop_o,
    output logic                   undef_o,
    output logic [WAY_W-1:0]       way_o,
    output logic [SET_W_MAX-1:0]   set_o,
    output logic [ADDR_W-1:0]      line_addr_o
);

    logic [NUM_OPS-1:0]   dec_strobe;
    logic                 dec_nop;
    logic                 dec_undef;
    fmt_e                 dec_fmt;
    logic [WAY_W-1:0]     fmt_way;
    logic [SET_W_MAX-1:0] fmt_set;
    logic [ADDR_W-1:0]    fmt_addr;

    cmo_table_decode i_table (
        .crm_i    (req_crm_i),
        .op2_i    (req_op2_i),
        .read_i   (req_read_i),
        .priv_i   (priv_i),
        .strobe_o (dec_strobe),
        .nop_o    (dec_nop),
        .undef_o  (dec_undef),
        .fmt_o    (dec_fmt)
    );

    cmo_operand_fmt #(
        .DATA_W      (DATA_W),
        .WAY_W       (WAY_W),
        .LINE_LSB    (LINE_LSB),
        .MIN_SET_W   (MIN_SET_W),
        .NUM_SIZES   (NUM_SIZES),
        .SIZE_CODE_W (SIZE_CODE_W)
    ) i_fmt (
        .wdata_i (req_wdata_i),
        .size_i  (cache_size_i),
        .fmt_i   (dec_fmt),
        .way_o   (fmt_way),
        .set_o   (fmt_set),
        .addr_o  (fmt_addr)
    );

    // Output register: outcome and operand live for one cycle per request.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid_i) begin
            op_strobe_o <= '0;
            nop_o       <= 1'b0;
            undef_o     <= 1'b0;
            way_o       <= '0;
            set_o       <= '0;
            line_addr_o <= '0;
        end else begin
            op_strobe_o <= dec_strobe;
            nop_o       <= dec_nop;
            undef_o     <= dec_undef;
            way_o       <= fmt_way;
            set_o       <= fmt_set;
            line_addr_o <= fmt_addr;
        end
    end

    // ---------------- assertions ----------------
    assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> ($countones({op_strobe_o, nop_o, undef_o}) == 1));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> ({op_strobe_o, nop_o, undef_o} == '0));

    assert_read_traps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_read_i) |=> undef_o);

    assert_user_barriers_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !priv_i) |=> (((op_strobe_o & ~USER_MASK) == '0) && !nop_o));

    assert_small_set_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && cache_size_i == '0) |=> (set_o[SET_W_MAX-1:MIN_SET_W] == '0));

    assert_bad_size_as_small_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && int'(cache_size_i) >= NUM_SIZES) |=> (set_o[SET_W_MAX-1:MIN_SET_W] == '0));

    assert_addr_only_addr_ops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (line_addr_o != '0) |-> ((op_strobe_o & ADDR_MASK) != '0));

    assert_way_only_setway_ops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((way_o != '0) || (set_o != '0)) |-> ((op_strobe_o & SETWAY_MASK) != '0));

endmodule

// File: tb/test_cmo_decoder.sv
// Bench: mixes directed corner cases with seeded random accesses and
// checks every registered outcome against an independent model.
module test_cmo_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 7411;
    localparam int N_RANDOM   = 800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_read = 1'b0;
    logic [3:0]  req_crm = '0;
    logic [2:0]  req_op2 = '0;
    logic [31:0] req_wdata = '0;
    logic        priv = 1'b1;
    logic [2:0]  cache_size = '0;
    logic [12:0] op_strobe;
    logic        nop;
    logic        undef;
    logic [1:0]  way;
    logic [8:0]  set_idx;
    logic [26:0] line_addr;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmo_decoder i_cmo_decoder (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid),
        .req_read_i   (req_read),
        .req_crm_i    (req_crm),
        .req_op2_i    (req_op2),
        .req_wdata_i  (req_wdata),
        .priv_i       (priv),
        .cache_size_i (cache_size),
        .op_strobe_o  (op_strobe),
        .nop_o        (nop),
        .undef_o      (undef),
        .way_o        (way),
        .set_o        (set_idx),
        .line_addr_o  (line_addr)
    );

    // Model of the table in R4/R6: returns index, or -1 for nop, -2 for undefined pair.
    // fmt: 0 none, 1 set/way, 2 address.
    function automatic void ref_table(input logic [3:0] c, input logic [2:0] o,
                                      output int idx, output int fmt, output bit user_ok);
        idx = -2; fmt = 0; user_ok = 0;
        case ({c, o})
            {4'd5, 3'd0}:  idx = 0;
            {4'd1, 3'd0}:  idx = 1;
            {4'd5, 3'd1}:  begin idx = 2;  fmt = 2; end
            {4'd5, 3'd4}:  begin idx = 3;  user_ok = 1; end
            {4'd6, 3'd1}:  begin idx = 4;  fmt = 2; end
            {4'd6, 3'd2}:  begin idx = 5;  fmt = 1; end
            {4'd10, 3'd1}: begin idx = 6;  fmt = 2; end
            {4'd10, 3'd2}: begin idx = 7;  fmt = 1; end
            {4'd10, 3'd4}: begin idx = 8;  user_ok = 1; end
            {4'd10, 3'd5}: begin idx = 9;  user_ok = 1; end
            {4'd11, 3'd1}: begin idx = 10; fmt = 2; end
            {4'd14, 3'd1}: begin idx = 11; fmt = 2; end
            {4'd14, 3'd2}: begin idx = 12; fmt = 1; end
            {4'd0, 3'd4}, {4'd1, 3'd6}, {4'd5, 3'd6}, {4'd5, 3'd7}: idx = -1;
            default: idx = -2;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request at a falling edge; check it at the next falling edge.
    task automatic run_req(input bit rd, input logic [3:0] c, input logic [2:0] o,
                           input logic [31:0] d, input bit pv, input logic [2:0] sz);
        int idx; int fmt; bit uok; bit ok;
        logic [12:0] e_strobe; logic e_nop; logic e_undef;
        logic [1:0] e_way; logic [8:0] e_set; logic [26:0] e_addr;
        int w; string otag; string ftag;
        req_valid = 1; req_read = rd; req_crm = c; req_op2 = o;
        req_wdata = d; priv = pv; cache_size = sz;
        @(negedge clk);
        req_valid = 0;
        ref_table(c, o, idx, fmt, uok);
        ok = !rd && (idx != -2) && (pv || uok);
        e_strobe = '0; e_nop = 0; e_undef = 0; e_way = '0; e_set = '0; e_addr = '0;
        if (!ok) e_undef = 1;
        else if (idx == -1) e_nop = 1;
        else begin
            e_strobe[idx] = 1'b1;
            w = (sz <= 3'd4) ? 5 + int'(sz) : 5;
            if (fmt == 1) begin
                e_way = d[31:30];
                for (int b = 0; b < 9; b++) if (b < w) e_set[b] = d[5 + b];
            end else if (fmt == 2) e_addr = d[31:5];
        end
        if (rd) otag = "R2";
        else if (idx == -2) otag = "R3";
        else if (!pv) otag = "R5";
        else if (idx == -1) otag = "R4";
        else otag = "R6";
        check({otag, " outcome"}, 64'({op_strobe, nop, undef}), 64'({e_strobe, e_nop, e_undef}));
        check("R7 single outcome", 64'($countones({op_strobe, nop, undef})), 64'd1);
        if (ok && fmt == 1) ftag = (sz > 3'd4) ? "R9" : "R8";
        else if (ok && fmt == 2) ftag = "R10";
        else ftag = "R11";
        check({ftag, " operand"}, 64'({way, set_idx, line_addr}), 64'({e_way, e_set, e_addr}));
    endtask

    task automatic idle_check;
        @(negedge clk);
        check("R7 idle", 64'({op_strobe, nop, undef, way, set_idx, line_addr}), 64'd0);
    endtask

    localparam logic [6:0] PAIRS [17] = '{
        {4'd5,3'd0}, {4'd1,3'd0}, {4'd5,3'd1}, {4'd5,3'd4}, {4'd6,3'd1}, {4'd6,3'd2},
        {4'd10,3'd1}, {4'd10,3'd2}, {4'd10,3'd4}, {4'd10,3'd5}, {4'd11,3'd1},
        {4'd14,3'd1}, {4'd14,3'd2}, {4'd0,3'd4}, {4'd1,3'd6}, {4'd5,3'd6}, {4'd5,3'd7}};

    initial begin
        int unsigned seed_use;
        seed_use = $urandom(SEED);
        req_valid = 1;  // a request held during reset must not appear (R1)
        req_crm = 4'd10; req_op2 = 3'd4;
        repeat (3) @(negedge clk);
        check("R1 reset state", 64'({op_strobe, nop, undef, way, set_idx, line_addr}), 64'd0);
        req_valid = 0;
        rst_n = 1;
        @(negedge clk);
        check("R1 after release", 64'({op_strobe, nop, undef, way, set_idx, line_addr}), 64'd0);

        // Directed corners.
        run_req(1, 4'd10, 3'd4, 32'h0, 1, 3'd0);          // R2 read of a barrier
        run_req(0, 4'd7,  3'd0, 32'h0, 1, 3'd0);          // R3 undefined pair
        run_req(0, 4'd0,  3'd4, 32'hFFFF_FFFF, 1, 3'd2);  // R4 nop, operands zero
        run_req(0, 4'd0,  3'd4, 32'h0, 0, 3'd0);          // R5 nop in user mode
        run_req(0, 4'd10, 3'd5, 32'h0, 0, 3'd0);          // R5 barrier in user mode
        run_req(0, 4'd6,  3'd2, 32'h0, 0, 3'd0);          // R5 set/way op in user mode
        run_req(0, 4'd6,  3'd2, 32'hFFFF_FFFF, 1, 3'd0);  // R8 4KB, SBZ bits set
        run_req(0, 4'd14, 3'd2, 32'hFFFF_FFFF, 1, 3'd4);  // R8 64KB full set
        run_req(0, 4'd10, 3'd2, 32'hBFFF_FFFF, 1, 3'd7);  // R9 bad size code
        run_req(0, 4'd5,  3'd1, 32'hFFFF_FFFF, 1, 3'd3);  // R10 SBZ offset ignored
        idle_check();

        for (int i = 0; i < N_RANDOM; i++) begin
            logic [3:0] c; logic [2:0] o; bit rd; bit pv;
            if ($urandom_range(1, 0) == 1) {c, o} = PAIRS[$urandom_range(16, 0)];
            else {c, o} = 7'($urandom);
            rd = ($urandom_range(7, 0) == 0);
            pv = ($urandom_range(3, 0) != 0);
            run_req(rd, c, o, $urandom, pv, 3'($urandom));
            if ($urandom_range(9, 0) == 0) idle_check();
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule